// File: doc/BRIEF.md
# Configuration Memory Boot Loader

This block runs the off-line phase of a small coprocessor. While the `offline` input is high, it takes a stream of bytes from an 8-bit input bus and turns them into writes on a simple RAM write port. It marks the end of loading with a `done` flag. The on-line phase may start only after `offline` has been taken low again.

Bytes can arrive in two ways. In automatic mode (`auto_boot` high), the block divides its clock to make a single-cycle `boot_strobe` pulse toward an external byte-wide memory. A 3-bit speed select picks the divide ratio, and the byte on `din` is captured on each pulse. In manual mode a host raises `rd_in` for each byte, and the block answers with `rdy`.

The stream is made of two-byte records. Each record is an address byte followed by a data byte. A record whose address byte is 0xFF ends loading. The active-low `preset_n` input and every change of `offline` hold the block in reset for a short, fixed time.

Top module: `cfg_boot_loader`

## Requirements
- R1: While `preset_n` is low, and on the first three clock edges that sample it high again, the block is held in reset. During this time `wr_en`, `done`, `rdy` and `boot_strobe` are 0, and `rd_in` activity is ignored.
- R2: A clock edge at which `offline` differs from its value at the previous edge begins a hold. The hold covers that edge and the three edges after it. It clears `done` and the record state, and `rd_in` activity during it is ignored.
- R3: While `offline` is low, no byte is captured: `rdy` stays 0, `boot_strobe` stays 0 and `wr_en` stays 0.
- R4: In automatic mode `boot_strobe` is high for exactly one clock cycle in each period. The byte on `din` is captured at the rising edge that ends that cycle.
- R5: The strobe period in clock cycles depends on `speed_sel`, with bit 0 as the least significant bit: 0→32, 1→16, 2→64, 3→128, 4→8, 5→4, 6→2, 7→256.
- R6: In manual mode a rising edge of `rd_in` (high at a clock edge after being low at the previous edge, with `rdy` low) captures `din`. `rdy` is high from the next cycle and stays high until `rd_in` is sampled low. Only after that is a new rising edge accepted.
- R7: Captured bytes alternate between address and data, starting with address. The cycle after a data byte is captured, `wr_en` is high for one cycle, with `wr_addr` set to the preceding address byte and `wr_data` set to the data byte.
- R8: An address byte equal to 0xFF makes no write. It sets `done` high from the next cycle, and `done` stays high until a hold from R1 or R2.
- R9: While `done` is high, no more bytes are captured: `boot_strobe` stays 0 and `rdy` does not answer `rd_in`.
- R10: With `auto_boot` low, `boot_strobe` never pulses. With `auto_boot` high, `rd_in` is ignored and `rdy` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| preset_n | input | 1 | Active-low restart |
| offline | input | 1 | High enables loading |
| auto_boot | input | 1 | High selects automatic mode, low selects manual handshake |
| speed_sel | input | 3 | Strobe divide-ratio select in automatic mode |
| din | input | 8 | Address and data byte bus |
| rd_in | input | 1 | Manual read strobe from the host, active high |
| rdy | output | 1 | Manual mode: byte captured, waiting for `rd_in` to drop |
| boot_strobe | output | 1 | Automatic mode: single-cycle read pulse toward external memory |
| wr_en | output | 1 | RAM write enable, one-cycle pulse |
| wr_addr | output | 8 | RAM write address |
| wr_data | output | 8 | RAM write data |
| done | output | 1 | Loading complete |

## Verification
The assertions check the behaviour that holds on every cycle:
- the hold of three edges after preset release;
- `boot_strobe` and `wr_en` never being high on two cycles in a row;
- `rdy` rising only after `rd_in` was high and staying high while `rd_in` stays high;
- `done` staying high once set.

The scenarios are needed for the rest:
- the exact strobe period for each speed code;
- the address and data pairing seen on the write port;
- the terminal record;
- bytes being ignored during a hold, after `done`, with `offline` low, and in the mode that is not selected.

// File: rtl/cbl_pkg.sv
package cbl_pkg;

  typedef enum logic {
    PH_ADDR = 1'b0,
    PH_DATA = 1'b1
  } rec_phase_e;

  // log2 of the strobe period for each speed code
  function automatic logic [3:0] div_log2(input logic [2:0] sel);
    logic [3:0] r;
    case (sel)
      3'd0:    r = 4'd5;
      3'd1:    r = 4'd4;
      3'd2:    r = 4'd6;
      3'd3:    r = 4'd7;
      3'd4:    r = 4'd3;
      3'd5:    r = 4'd2;
      3'd6:    r = 4'd1;
      default: r = 4'd8;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cbl_reset_hold.sv
module cbl_reset_hold #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic preset_n,
  input  logic offline,
  output logic hold
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          off_q;
  logic [CW-1:0] cnt;
  logic          trig;

  assign trig = !preset_n || (offline != off_q);
  assign hold = trig || (cnt != '0);

  always_ff @(posedge clk) begin
    off_q <= offline;
    if (trig)
      cnt <= CW'(HOLD_CYC);
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  // R1: three held edges after preset release (default HOLD_CYC)
  assert_hold_after_preset_R1: assert property (@(posedge clk)
    $rose(preset_n) |-> hold ##1 hold ##1 hold);

endmodule

// File: rtl/cbl_strobe_gen.sv
module cbl_strobe_gen #(
  parameter int CNT_W = 9
) (
  input  logic       clk,
  input  logic       run,
  input  logic [2:0] sel,
  output logic       tick
);
  import cbl_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  assign lim  = (CNT_W'(1) << div_log2(sel)) - CNT_W'(1);
  assign tick = run && (cnt >= lim);

  always_ff @(posedge clk) begin
    if (!run)
      cnt <= '0;
    else if (cnt >= lim)
      cnt <= '0;
    else
      cnt <= cnt + CNT_W'(1);
  end

  // R4: strobe is a single-cycle pulse
  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!run)
    tick |=> !tick);

endmodule

// File: rtl/cbl_hs_capture.sv
module cbl_hs_capture (
  input  logic clk,
  input  logic hold,
  input  logic run,
  input  logic rd_in,
  output logic take,
  output logic rdy
);
  logic rd_q;

  assign take = run && rd_in && !rd_q && !rdy;

  always_ff @(posedge clk) begin
    rd_q <= rd_in;
    if (hold)
      rdy <= 1'b0;
    else if (rdy && !rd_in)
      rdy <= 1'b0;
    else if (take)
      rdy <= 1'b1;
  end

  // R6: ready holds while the host keeps its strobe up
  assert_rdy_holds_R6: assert property (@(posedge clk) disable iff (hold)
    (rdy && rd_in) |=> rdy);

  // R6: ready only rises after the strobe was seen high
  assert_rdy_needs_rd_R6: assert property (@(posedge clk) disable iff (hold)
    $rose(rdy) |-> $past(rd_in));

endmodule

// File: rtl/cbl_rec_parser.sv
module cbl_rec_parser #(
  parameter int DW = 8,
  parameter int AW = 8,
  parameter logic [DW-1:0] END_CODE = '1
) (
  input  logic          clk,
  input  logic          hold,
  input  logic          take,
  input  logic [DW-1:0] din,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done
);
  import cbl_pkg::*;

  rec_phase_e    phase;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (hold) begin
      phase   <= PH_ADDR;
      wr_en   <= 1'b0;
      done    <= 1'b0;
      addr_q  <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (take) begin
        if (phase == PH_ADDR) begin
          if (din == END_CODE)
            done <= 1'b1;
          else begin
            addr_q <= din[AW-1:0];
            phase  <= PH_DATA;
          end
        end else begin
          wr_en   <= 1'b1;
          wr_addr <= addr_q;
          wr_data <= din;
          phase   <= PH_ADDR;
        end
      end
    end
  end

  // R7: writes are single-cycle pulses
  assert_wr_single_R7: assert property (@(posedge clk) disable iff (hold)
    wr_en |=> !wr_en);

  // R8: completion flag is sticky until a hold
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (hold)
    done |=> done);

endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader #(
  parameter int DW       = 8,
  parameter int AW       = 8,
  parameter int HOLD_CYC = 3,
  parameter int CNT_W    = 9
) (
  input  logic          clk,
  input  logic          preset_n,
  input  logic          offline,
  input  logic          auto_boot,
  input  logic [2:0]    speed_sel,
  input  logic [DW-1:0] din,
  input  logic          rd_in,
  output logic          rdy,
  output logic          boot_strobe,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          done
);
  logic hold;
  logic run_any, run_auto, run_man;
  logic tick, take_man, take;

  cbl_reset_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .preset_n(preset_n), .offline(offline), .hold(hold)
  );

  assign run_any  = offline && !hold && !done;
  assign run_auto = run_any && auto_boot;
  assign run_man  = run_any && !auto_boot;

  cbl_strobe_gen #(.CNT_W(CNT_W)) u_strobe (
    .clk(clk), .run(run_auto), .sel(speed_sel), .tick(tick)
  );

  cbl_hs_capture u_hs (
    .clk(clk), .hold(hold), .run(run_man), .rd_in(rd_in),
    .take(take_man), .rdy(rdy)
  );

  assign take        = tick || take_man;
  assign boot_strobe = tick;

  cbl_rec_parser #(.DW(DW), .AW(AW), .END_CODE({DW{1'b1}})) u_parse (
    .clk(clk), .hold(hold), .take(take), .din(din),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  // R8: completion follows a captured byte
  assert_done_after_byte_R8: assert property (@(posedge clk) disable iff (hold)
    $rose(done) |-> $past(take));

  // R3: the strobe never runs with loading disabled
  assert_strobe_offline_R3: assert property (@(posedge clk) disable iff (!preset_n)
    boot_strobe |-> offline);

endmodule

// File: tb/cfg_boot_loader_tb.sv
module cfg_boot_loader_tb;
  logic       clk = 1'b0;
  logic       preset_n, offline, auto_boot, rd_in;
  logic [2:0] speed_sel;
  logic [7:0] din;
  logic       rdy, boot_strobe, wr_en, done;
  logic [7:0] wr_addr, wr_data;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int stray  = 0;
  logic [15:0] exp_q[$];

  logic [7:0] fmem [3];
  int  fidx   = 0;
  bit  feed_on = 1'b0;
  bit  adv    = 1'b0;

  always #2 clk = ~clk;

  cfg_boot_loader u_dut (
    .clk(clk), .preset_n(preset_n), .offline(offline), .auto_boot(auto_boot),
    .speed_sel(speed_sel), .din(din), .rd_in(rd_in), .rdy(rdy),
    .boot_strobe(boot_strobe), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int period_of(input int sel);
    int tbl [8] = '{32, 16, 64, 128, 8, 4, 2, 256};
    return tbl[sel];
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (preset_n === 1'b1 && wr_en === 1'b1) begin
      if (exp_q.size() == 0)
        chk(1'b0, "R7", "unexpected write addr", int'(wr_addr), -1);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk({wr_addr, wr_data} == e, "R7", "write addr/data",
            int'({wr_addr, wr_data}), int'(e));
      end
    end
    if (auto_boot === 1'b0 && boot_strobe === 1'b1) stray++;
  end

  // external memory model for automatic mode
  always @(negedge clk) begin
    if (feed_on) begin
      if (adv) begin
        if (fidx < 2) fidx++;
        din = fmem[fidx];
        adv = 1'b0;
      end
      if (boot_strobe) adv = 1'b1;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send_byte(input logic [7:0] b);
    chk(rdy == 1'b0, "R6", "rdy idle before strobe", rdy, 0);
    din   = b;
    rd_in = 1'b1;
    @(negedge clk);
    chk(rdy == 1'b1, "R6", "rdy one cycle after rd rise", rdy, 1);
    repeat (2) @(negedge clk);
    chk(rdy == 1'b1, "R6", "rdy held while rd high", rdy, 1);
    rd_in = 1'b0;
    @(negedge clk);
    chk(rdy == 1'b0, "R6", "rdy drops after rd low", rdy, 0);
  endtask

  task automatic send_rec(input logic [7:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    send_byte(a);
    send_byte(d);
  endtask

  task automatic auto_run(input int sel, input logic [7:0] a, input logic [7:0] d);
    int n;
    int t;
    offline = 1'b0;
    repeat (6) @(negedge clk);
    auto_boot = 1'b1;
    speed_sel = 3'(sel);
    fmem[0] = a; fmem[1] = d; fmem[2] = 8'hFF;
    fidx = 0; adv = 1'b0; din = a; feed_on = 1'b1;
    exp_q.push_back({a, d});
    rd_in   = 1'b1;   // R10: ignored in automatic mode
    offline = 1'b1;
    t = 0;
    while (boot_strobe !== 1'b1 && t < 2000) begin @(negedge clk); t++; end
    n = 0;
    @(negedge clk); n++;
    while (boot_strobe !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
    chk(n == period_of(sel), "R5", $sformatf("period for code %0d", sel), n, period_of(sel));
    t = 0;
    while (done !== 1'b1 && t < 2000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R8", "done after auto image", done, 1);
    t = 0;
    repeat (300) begin @(negedge clk); if (boot_strobe) t++; end
    chk(t == 0, "R9", "no strobe after done", t, 0);
    chk(rdy == 1'b0, "R10", "rdy silent in auto mode", rdy, 0);
    rd_in = 1'b0;
    feed_on = 1'b0;
  endtask

  initial begin
    preset_n = 1'b0; offline = 1'b1; auto_boot = 1'b0; speed_sel = 3'd0;
    din = 8'h00; rd_in = 1'b0;
    repeat (3) @(negedge clk);
    chk({wr_en, done, rdy, boot_strobe} == 4'b0, "R1", "outputs in reset",
        int'({wr_en, done, rdy, boot_strobe}), 0);

    // R1: a strobe raised within the held edges is ignored
    preset_n = 1'b1;
    repeat (2) @(negedge clk);
    din = 8'h55; rd_in = 1'b1;
    repeat (5) @(negedge clk);
    chk(rdy == 1'b0, "R1", "rd during post-preset hold ignored", rdy, 0);
    rd_in = 1'b0;
    repeat (2) @(negedge clk);

    // R6/R7: manual records
    send_rec(8'h10, 8'hA5);
    send_rec(8'h00, 8'h3C);
    send_rec(8'hFE, 8'hFF);
    send_byte(8'hFF);
    chk(done == 1'b1, "R8", "done after terminal address", done, 1);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R7", "all manual writes seen", exp_q.size(), 0);

    // R9: no answer after done
    rd_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdy == 1'b0, "R9", "rd ignored after done", rdy, 0);
    rd_in = 1'b0;
    @(negedge clk);

    // R2: dropping offline clears done
    offline = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R2", "done cleared by offline change", done, 1'b0);
    repeat (6) @(negedge clk);

    // R3: no capture with offline low
    rd_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdy == 1'b0, "R3", "rd ignored while offline low", rdy, 0);
    rd_in = 1'b0;
    @(negedge clk);

    // R2: rd during hold after offline rise is ignored
    offline = 1'b1;
    repeat (3) @(negedge clk);
    rd_in = 1'b1;
    repeat (4) @(negedge clk);
    chk(rdy == 1'b0, "R2", "rd during offline-change hold ignored", rdy, 0);
    rd_in = 1'b0;
    repeat (2) @(negedge clk);
    send_rec(8'h21, 8'h5A);
    send_byte(8'hFF);
    chk(done == 1'b1, "R8", "done after second manual image", done, 1);
    chk(stray == 0, "R10", "no strobe in manual mode", stray, 0);

    // R4/R5: automatic mode at several speeds
    auto_run(0, 8'h40, 8'h11);
    auto_run(1, 8'h41, 8'h22);
    auto_run(6, 8'h42, 8'h33);
    auto_run(4, 8'h43, 8'h44);
    auto_run(7, 8'h44, 8'h55);
    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R4", "all auto writes seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule